// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Lockout

This block lives inside an SDRAM controller and decides when auto-refresh commands are owed. A free-running interval counter produces one tick per average refresh period, and each tick adds one refresh to a debt counter. The debt may grow up to a cap of eight. While the debt is below the cap the scheduler raises a low-priority refresh request, so the command arbiter can let pending traffic go first. At the cap it also raises an urgent flag, and the arbiter must then service refresh before anything else. Each grant that the arbiter returns while the request is up pays off one refresh. It also starts a refresh-cycle hold-off, and during that hold-off no further grant is taken.

The block also tracks self-refresh. An entry pulse clears the debt and freezes the interval counter. An exit pulse restarts the interval counter from zero. It also opens three lockout windows. Non-read commands, including refresh, stay blocked for one window. Reads stay blocked for a longer, fixed window of clock cycles. Writes stay blocked until the non-read window and a row-activate-to-column delay have both passed. All durations are parameters counted in clock cycles. With a 133 MHz clock, the defaults give about 1037 cycles per refresh interval, 11 cycles for the non-read window and 200 cycles for the read window.

Top module: `refresh_sched`

## Requirements
- R1: The owed-refresh count increases by one every INTERVAL_CYC clock edges. The first increase happens at the INTERVAL_CYC-th edge after reset is released.
- R2: `ref_req_o` is high exactly when all four of these hold: the debt is non-zero, the block is out of self-refresh, non-read commands are permitted, and the refresh-cycle hold-off has expired.
- R3: The debt saturates at MAX_DEBT, so further ticks leave it there. `ref_urgent_o` is high exactly when the debt equals MAX_DEBT.
- R4: A grant taken while `ref_req_o` is high lowers the debt by one. A grant that arrives while `ref_req_o` is low has no effect.
- R5: When an interval tick and an accepted grant fall on the same edge, the debt is unchanged.
- R6: After an accepted grant, `ref_req_o` stays low for the next TRFC_CYC-1 cycles. The next grant can therefore be taken no sooner than TRFC_CYC edges after the previous one.
- R7: An entry pulse given outside self-refresh sets `sr_active_o` at the next edge and clears the debt. While `sr_active_o` is high, the debt does not grow, `ref_req_o` is low, and grants and further entry pulses are ignored.
- R8: An exit pulse given during self-refresh clears `sr_active_o` and restarts the interval counter. The first debt increase then comes INTERVAL_CYC edges after the exit edge.
- R9: `nonread_ok_o` is low during self-refresh and for XS_NONREAD_CYC edges after the exit edge. It rises after the XS_NONREAD_CYC-th edge.
- R10: `read_ok_o` is low during self-refresh and for XS_READ_CYC edges after the exit edge. It rises after the XS_READ_CYC-th edge.
- R11: `write_ok_o` is low during self-refresh and rises after XS_NONREAD_CYC+TRCD_CYC edges following the exit edge.
- R12: While reset is held and right after it, the debt is 0, `ref_req_o`, `ref_urgent_o` and `sr_active_o` are low, and all three permits are high. An exit pulse given outside self-refresh changes none of these outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sr_enter_i | input | 1 | One-cycle request to enter self-refresh |
| sr_exit_i | input | 1 | One-cycle request to leave self-refresh |
| ref_gnt_i | input | 1 | Arbiter grant for the refresh request |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Refresh must preempt all other traffic |
| debt_o | output | $clog2(MAX_DEBT+1) | Number of refreshes owed |
| sr_active_o | output | 1 | Device is in self-refresh |
| nonread_ok_o | output | 1 | Commands other than reads may be issued |
| read_ok_o | output | 1 | Reads may be issued |
| write_ok_o | output | 1 | Writes may be issued |

## Verification
Two situations are hard to reach. The first is a debt that is non-zero while the non-read lockout is still running after self-refresh exit, which is the only moment the request is blocked by the lockout alone. The bench gets there by using a refresh interval shorter than the non-read window, so a tick lands inside the window. The second is a tick and an accepted grant on the same edge. The bench reaches it by counting edges from reset, so that the grant is driven exactly on the tick edge.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    // Index of each post-exit lockout window
    localparam int LK_NONREAD = 0;
    localparam int LK_READ    = 1;
    localparam int LK_WRITE   = 2;
    localparam int LK_COUNT   = 3;

    typedef enum logic {
        SR_OFF = 1'b0,
        SR_ON  = 1'b1
    } sr_state_e;

    typedef struct packed {
        logic nonread;
        logic read;
        logic write;
    } cmd_permit_t;

    // Bits needed to hold values 0..v
    function automatic int unsigned cnt_w(input int unsigned v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
    parameter int unsigned INTERVAL_CYC = 1037
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned CW = refresh_pkg::cnt_w(INTERVAL_CYC);

    logic [CW-1:0] cnt;

    assign tick_o = !hold_i && (cnt == CW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the counter wraps after each tick
    assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt == '0));

    // R1: the counter never passes the period
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(INTERVAL_CYC));

endmodule

// File: rtl/ref_debt_ctrl.sv
module ref_debt_ctrl #(
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned TRFC_CYC = 10,
    localparam int unsigned DW = refresh_pkg::cnt_w(MAX_DEBT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          gnt_i,
    input  logic          clear_i,
    input  logic          block_i,
    output logic          req_o,
    output logic          urgent_o,
    output logic [DW-1:0] debt_o
);
    localparam int unsigned RW = refresh_pkg::cnt_w(TRFC_CYC);

    logic [DW-1:0] debt;
    logic [RW-1:0] rfc_cnt;
    logic          accept;
    logic          at_cap;

    assign at_cap   = (debt == DW'(MAX_DEBT));
    assign req_o    = (debt != '0) && !block_i && (rfc_cnt == '0);
    assign accept   = req_o && gnt_i;
    assign urgent_o = at_cap;
    assign debt_o   = debt;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            debt <= '0;
        end else begin
            unique case ({tick_i, accept})
                2'b10:   if (!at_cap) debt <= debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rfc_cnt <= '0;
        end else if (accept) begin
            rfc_cnt <= RW'(TRFC_CYC - 1);
        end else if (rfc_cnt != '0) begin
            rfc_cnt <= rfc_cnt - 1'b1;
        end
    end

    // R3: the debt never exceeds its cap
    assert_debt_cap_R3: assert property (@(posedge clk) disable iff (rst)
        debt <= DW'(MAX_DEBT));

    // R4: outside a clear, the debt moves by at most one per edge
    assert_debt_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(clear_i) |-> (debt == $past(debt) || debt == $past(debt) + 1'b1
                             || debt == $past(debt) - 1'b1));

    // R6: no request in the cycle right after an accepted grant
    assert_rfc_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && TRFC_CYC > 1) |=> !req_o);

endmodule

// File: rtl/ref_countdown.sv
module ref_countdown #(
    parameter int unsigned LOAD_VAL = 200,
    parameter int unsigned W        = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= W'(LOAD_VAL);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero_o = (cnt == '0);

    // R9: a lockout window never runs longer than its load
    assert_lock_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(LOAD_VAL));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned INTERVAL_CYC   = 1037,
    parameter int unsigned MAX_DEBT       = 8,
    parameter int unsigned TRFC_CYC       = 10,
    parameter int unsigned XS_NONREAD_CYC = 11,
    parameter int unsigned XS_READ_CYC    = 200,
    parameter int unsigned TRCD_CYC       = 3,
    localparam int unsigned DW = refresh_pkg::cnt_w(MAX_DEBT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sr_enter_i,
    input  logic          sr_exit_i,
    input  logic          ref_gnt_i,
    output logic          ref_req_o,
    output logic          ref_urgent_o,
    output logic [DW-1:0] debt_o,
    output logic          sr_active_o,
    output logic          nonread_ok_o,
    output logic          read_ok_o,
    output logic          write_ok_o
);
    import refresh_pkg::*;

    localparam int unsigned WR_LOCK = XS_NONREAD_CYC + TRCD_CYC;
    localparam int unsigned LW = cnt_w(max3(XS_NONREAD_CYC, XS_READ_CYC, WR_LOCK));
    localparam int unsigned LOCK_LOAD [LK_COUNT] = '{XS_NONREAD_CYC, XS_READ_CYC, WR_LOCK};

    sr_state_e   sr_state;
    logic        enter_evt;
    logic        exit_evt;
    logic        tick;
    logic        in_sr;
    logic [LK_COUNT-1:0] lock_done;
    cmd_permit_t permit;

    assign in_sr     = (sr_state == SR_ON);
    assign enter_evt = !in_sr && sr_enter_i;
    assign exit_evt  = in_sr && sr_exit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_state <= SR_OFF;
        end else if (enter_evt) begin
            sr_state <= SR_ON;
        end else if (exit_evt) begin
            sr_state <= SR_OFF;
        end
    end

    ref_tick_gen #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .hold_i (in_sr),
        .tick_o (tick)
    );

    for (genvar g = 0; g < LK_COUNT; g++) begin : g_lock
        ref_countdown #(.LOAD_VAL(LOCK_LOAD[g]), .W(LW)) u_cd (
            .clk    (clk),
            .rst    (rst),
            .load_i (exit_evt),
            .zero_o (lock_done[g])
        );
    end

    assign permit.nonread = !in_sr && lock_done[LK_NONREAD];
    assign permit.read    = !in_sr && lock_done[LK_READ];
    assign permit.write   = !in_sr && lock_done[LK_WRITE];

    ref_debt_ctrl #(.MAX_DEBT(MAX_DEBT), .TRFC_CYC(TRFC_CYC)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .gnt_i    (ref_gnt_i),
        .clear_i  (enter_evt),
        .block_i  (!permit.nonread),
        .req_o    (ref_req_o),
        .urgent_o (ref_urgent_o),
        .debt_o   (debt_o)
    );

    assign sr_active_o  = in_sr;
    assign nonread_ok_o = permit.nonread;
    assign read_ok_o    = permit.read;
    assign write_ok_o   = permit.write;

    // R7: no refresh request while the device refreshes itself
    assert_sr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sr_active_o |-> !ref_req_o);

    // R7: entry leaves no debt behind
    assert_sr_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_active_o) |-> (debt_o == '0));

    // R10: reads are still locked out right after exit
    assert_read_lock_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_active_o) |-> !read_ok_o);

    // R11: a write is never permitted before other commands are
    assert_write_order_R11: assert property (@(posedge clk) disable iff (rst)
        write_ok_o |-> nonread_ok_o);

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int INTERVAL = 20;
    localparam int MAXD     = 8;
    localparam int TRFC     = 4;
    localparam int NONREAD  = 25;
    localparam int READ     = 40;
    localparam int TRCD     = 3;
    localparam int DW       = $clog2(MAXD + 1);

    // {edges to run, expected debt, expected urgent}
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{19, 0, 0}, '{1, 1, 0}, '{20, 2, 0},
        '{100, 7, 0}, '{20, 8, 1}, '{40, 8, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sr_enter = 1'b0, sr_exit = 1'b0, gnt = 1'b0;
    logic ref_req, ref_urgent, sr_active, nonread_ok, read_ok, write_ok;
    logic [DW-1:0] debt;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    refresh_sched #(
        .INTERVAL_CYC(INTERVAL), .MAX_DEBT(MAXD), .TRFC_CYC(TRFC),
        .XS_NONREAD_CYC(NONREAD), .XS_READ_CYC(READ), .TRCD_CYC(TRCD)
    ) u_refresh_sched (
        .clk(clk), .rst(rst), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
        .ref_gnt_i(gnt), .ref_req_o(ref_req), .ref_urgent_o(ref_urgent),
        .debt_o(debt), .sr_active_o(sr_active), .nonread_ok_o(nonread_ok),
        .read_ok_o(read_ok), .write_ok_o(write_ok)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; sr_enter = 1'b0; sr_exit = 1'b0; gnt = 1'b0;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        edges(1);
        do_reset();
        // R12 reset state
        chk("R12", "debt", int'(debt), 0);
        chk("R12", "req", int'(ref_req), 0);
        chk("R12", "urgent", int'(ref_urgent), 0);
        chk("R12", "sr_active", int'(sr_active), 0);
        chk("R12", "permits", int'({nonread_ok, read_ok, write_ok}), 7);

        // R4: grant with no request is ignored
        gnt = 1'b1; edges(1); gnt = 1'b0;
        chk("R4", "debt after idle grant", int'(debt), 0);
        chk("R4", "req after idle grant", int'(ref_req), 0);

        // R1 R3 vector walk from a fresh reset
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            edges(VEC[i][0]);
            chk("R1", "debt", int'(debt), VEC[i][1]);
            chk("R3", "urgent", int'(ref_urgent), VEC[i][2]);
            chk("R2", "req", int'(ref_req), (VEC[i][1] != 0) ? 1 : 0);
        end

        // R4 R6: grant at cap, held grant blocked during hold-off
        gnt = 1'b1; edges(1);
        chk("R4", "debt after grant", int'(debt), 7);
        chk("R3", "urgent below cap", int'(ref_urgent), 0);
        chk("R6", "req in hold-off", int'(ref_req), 0);
        edges(3);
        chk("R6", "debt during hold-off", int'(debt), 7);
        edges(1);
        gnt = 1'b0;
        chk("R6", "debt after second grant", int'(debt), 6);

        // R5: tick and grant on the same edge
        do_reset();
        edges(20);
        chk("R1", "first tick", int'(debt), 1);
        edges(19);
        gnt = 1'b1; edges(1); gnt = 1'b0;
        chk("R5", "debt tick+grant", int'(debt), 1);
        edges(2);
        chk("R6", "req still held off", int'(ref_req), 0);
        edges(1);
        chk("R6", "req back after hold-off", int'(ref_req), 1);

        // R12: exit outside self-refresh is ignored
        do_reset();
        sr_exit = 1'b1; edges(1); sr_exit = 1'b0;
        edges(1);
        chk("R12", "permits after stray exit", int'({nonread_ok, read_ok, write_ok}), 7);
        chk("R12", "sr after stray exit", int'(sr_active), 0);

        // R7..R11 self-refresh
        do_reset();
        edges(20);
        sr_enter = 1'b1; edges(1); sr_enter = 1'b0;
        chk("R7", "sr_active", int'(sr_active), 1);
        chk("R7", "debt cleared", int'(debt), 0);
        chk("R9", "nonread in sr", int'(nonread_ok), 0);
        chk("R10", "read in sr", int'(read_ok), 0);
        chk("R11", "write in sr", int'(write_ok), 0);
        gnt = 1'b1; sr_enter = 1'b1;
        edges(50);
        gnt = 1'b0; sr_enter = 1'b0;
        chk("R7", "debt frozen", int'(debt), 0);
        chk("R7", "req in sr", int'(ref_req), 0);
        chk("R7", "still in sr", int'(sr_active), 1);
        sr_exit = 1'b1; edges(1); sr_exit = 1'b0;
        chk("R8", "sr left", int'(sr_active), 0);
        chk("R9", "nonread locked", int'(nonread_ok), 0);
        edges(19);
        chk("R8", "no tick yet", int'(debt), 0);
        edges(1);
        chk("R8", "tick after exit", int'(debt), 1);
        chk("R2", "req blocked by lockout", int'(ref_req), 0);
        edges(4);
        chk("R9", "nonread at +24", int'(nonread_ok), 0);
        edges(1);
        chk("R9", "nonread at +25", int'(nonread_ok), 1);
        chk("R2", "req after lockout", int'(ref_req), 1);
        edges(2);
        chk("R11", "write at +27", int'(write_ok), 0);
        edges(1);
        chk("R11", "write at +28", int'(write_ok), 1);
        chk("R10", "read at +28", int'(read_ok), 0);
        edges(11);
        chk("R10", "read at +39", int'(read_ok), 0);
        edges(1);
        chk("R10", "read at +40", int'(read_ok), 1);
        chk("R1", "second tick after exit", int'(debt), 2);

        finish_run();
    end
endmodule